// File: doc/BRIEF.md
# Vector length configuration unit

This block sets the machine's vector length limits. A configure strobe gives the number of integer and floating-point registers that each vector element uses. From these the block derives how many elements fit in the register banks. It divides the bank capacity by one less than the total register count, scales the quotient by the number of banks, and clamps the result to the micro-thread limit. A small restoring divider inside the block does the division over a fixed number of cycles.

A set-length strobe carries the length the application asks for. The block grants the smaller of that request and the current maximum. Each result register raises its own done pulse when it is written. A new configuration leaves the granted length as it is, so software issues a new set-length after each configure.

Top module: `vl_cfg_unit`

## Requirements
- R1: After reset, `max_len_o`, `vl_o`, `busy_o`, `max_len_done_o` and `vl_done_o` are all zero.
- R2: When integer-used plus float-used is 0 or 1, the new maximum length is REGS_PER_BANK × BANK_COUNT, subject to R4.
- R3: When integer-used plus float-used is 2 or more, the new maximum length is floor(REGS_PER_BANK / (sum − 1)) × BANK_COUNT, subject to R4. This value may be zero.
- R4: `max_len_o` never exceeds MAX_THREADS.
- R5: A set-length strobe accepted while idle writes min(`max_len_o`, request) into `vl_o` on the next clock edge. If a configure strobe arrives in the same cycle, the old maximum is used.
- R6: A configure strobe accepted while idle raises `busy_o` for exactly DIV_W cycles, where DIV_W = $clog2(REGS_PER_BANK+1). `max_len_o` takes its new value on the edge where `busy_o` falls.
- R7: Set-length and configure strobes that arrive while `busy_o` is high are ignored.
- R8: A configure strobe never changes `vl_o`.
- R9: `max_len_done_o` and `vl_done_o` are each high for the one cycle after their register is written, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Configure strobe |
| cfg_int_used_i | input | CNT_W | Integer registers used per element |
| cfg_fp_used_i | input | CNT_W | Floating-point registers used per element |
| setvl_valid_i | input | 1 | Set-length strobe |
| setvl_req_i | input | REQ_W | Requested vector length |
| busy_o | output | 1 | Division in progress |
| max_len_o | output | LEN_W | Current maximum vector length |
| max_len_done_o | output | 1 | One-cycle pulse when the maximum is written |
| vl_o | output | LEN_W | Current granted vector length |
| vl_done_o | output | 1 | One-cycle pulse when the granted length is written |

## Verification
On every cycle the assertions check four things: the clamp bound, that a fresh grant never exceeds the maximum, that the granted length holds through a division and at its end, and that the maximum changes only together with its done pulse. The numerical values only show up in the bench's scenarios. These are the quotient for each register mix, the exact busy window, strobes dropped while busy, and the old maximum used when both strobes arrive together. The bench's reference model compares every output on every clock.

// File: rtl/vl_cfg_pkg.sv
package vl_cfg_pkg;
  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vl_div.sv
module vl_div #(
  parameter int DVD_W = 6,
  parameter int DVS_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int CW = (DVD_W > 1) ? $clog2(DVD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DVD_W - 1);

  logic             busy_q;
  logic [CW-1:0]    cnt_q;
  logic [DVS_W-1:0] rem_q, dvs_q, rem_n;
  logic [DVD_W-1:0] quo_q, quo_n;
  logic [DVS_W:0]   rem_sh;
  logic             fit;

  // one restoring step per cycle
  always_comb begin
    rem_sh = {rem_q, quo_q[DVD_W-1]};
    fit    = rem_sh >= {1'b0, dvs_q};
    rem_n  = DVS_W'(fit ? (rem_sh - {1'b0, dvs_q}) : rem_sh);
    quo_n  = {quo_q[DVD_W-2:0], fit};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= divisor_i;
      quo_q  <= dividend_i;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
  assign quot_o = quo_n;
endmodule

// File: rtl/vl_scale.sv
module vl_scale #(
  parameter int Q_W         = 6,
  parameter int BANK_COUNT  = 8,
  parameter int MAX_THREADS = 128,
  parameter int PROD_W      = 10,
  parameter int LEN_W       = 8
) (
  input  logic [Q_W-1:0]   quot_i,
  output logic [LEN_W-1:0] len_o
);
  logic [PROD_W-1:0] prod;

  always_comb begin
    prod  = PROD_W'(quot_i) * PROD_W'(BANK_COUNT);
    len_o = (prod > PROD_W'(MAX_THREADS)) ? LEN_W'(MAX_THREADS) : LEN_W'(prod);
  end
endmodule

// File: rtl/vl_cfg_unit.sv
module vl_cfg_unit
  import vl_cfg_pkg::*;
#(
  parameter int REGS_PER_BANK = 32,
  parameter int BANK_COUNT    = 8,
  parameter int MAX_THREADS   = 128,
  parameter int CNT_W         = 6,
  parameter int REQ_W         = 16,
  localparam int LEN_W        = $clog2(MAX_THREADS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_valid_i,
  input  logic [CNT_W-1:0] cfg_int_used_i,
  input  logic [CNT_W-1:0] cfg_fp_used_i,
  input  logic             setvl_valid_i,
  input  logic [REQ_W-1:0] setvl_req_i,
  output logic             busy_o,
  output logic [LEN_W-1:0] max_len_o,
  output logic             max_len_done_o,
  output logic [LEN_W-1:0] vl_o,
  output logic             vl_done_o
);
  localparam int DVD_W  = $clog2(REGS_PER_BANK + 1);
  localparam int DVS_W  = CNT_W + 1;
  localparam int PROD_W = $clog2(max_of(REGS_PER_BANK * BANK_COUNT, MAX_THREADS) + 1) + 1;

  logic [DVS_W-1:0] sum, divisor;
  logic             div_busy, div_done;
  logic [DVD_W-1:0] quot;
  logic [LEN_W-1:0] new_max;
  logic [LEN_W-1:0] max_q, vl_q;
  logic             mdone_q, vdone_q;

  always_comb begin
    sum     = DVS_W'(cfg_int_used_i) + DVS_W'(cfg_fp_used_i);
    divisor = (sum < DVS_W'(2)) ? DVS_W'(1) : sum - DVS_W'(1);
  end

  vl_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cfg_valid_i),
    .dividend_i (DVD_W'(REGS_PER_BANK)),
    .divisor_i  (divisor),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  vl_scale #(
    .Q_W(DVD_W), .BANK_COUNT(BANK_COUNT), .MAX_THREADS(MAX_THREADS),
    .PROD_W(PROD_W), .LEN_W(LEN_W)
  ) i_scale (
    .quot_i (quot),
    .len_o  (new_max)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_q   <= '0;
      vl_q    <= '0;
      mdone_q <= 1'b0;
      vdone_q <= 1'b0;
    end else begin
      mdone_q <= div_done;
      vdone_q <= 1'b0;
      if (div_done) max_q <= new_max;
      if (!div_busy && setvl_valid_i) begin
        vl_q    <= (setvl_req_i > REQ_W'(max_q)) ? max_q : LEN_W'(setvl_req_i);
        vdone_q <= 1'b1;
      end
    end
  end

  assign busy_o         = div_busy;
  assign max_len_o      = max_q;
  assign max_len_done_o = mdone_q;
  assign vl_o           = vl_q;
  assign vl_done_o      = vdone_q;
endmodule

// File: rtl/vl_cfg_checker.sv
module vl_cfg_checker #(
  parameter int MAX_THREADS = 128,
  parameter int LEN_W       = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic [LEN_W-1:0] max_len_o,
  input logic             max_len_done_o,
  input logic [LEN_W-1:0] vl_o,
  input logic             vl_done_o
);
  p_clamp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(max_len_o) <= MAX_THREADS);

  p_grant_le_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_done_o |-> vl_o <= max_len_o);

  p_busy_holds_vl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> $stable(vl_o));

  p_busy_end_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> max_len_done_o);

  p_cfg_keeps_vl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_len_done_o |-> ($stable(vl_o) && !vl_done_o));

  p_max_only_on_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !max_len_done_o |-> $stable(max_len_o));

  p_mdone_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_len_done_o |=> !max_len_done_o);
endmodule

bind vl_cfg_unit vl_cfg_checker #(.MAX_THREADS(MAX_THREADS), .LEN_W(LEN_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .busy_o         (busy_o),
  .max_len_o      (max_len_o),
  .max_len_done_o (max_len_done_o),
  .vl_o           (vl_o),
  .vl_done_o      (vl_done_o)
);

// File: tb/test_vl_cfg_unit.sv
module test_vl_cfg_unit;
  localparam int CLK_PERIOD = 10;
  localparam int R = 32, B = 8, T = 128, CNT_W = 6, REQ_W = 16;
  localparam int LEN_W = $clog2(T + 1);
  localparam int DIV_W = $clog2(R + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_v = 1'b0, sv_v = 1'b0;
  logic [CNT_W-1:0] iu = '0, fu = '0;
  logic [REQ_W-1:0] req = '0;
  logic busy;
  logic [LEN_W-1:0] max_len, vl;
  logic mdone, vdone;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  vl_cfg_unit #(.REGS_PER_BANK(R), .BANK_COUNT(B), .MAX_THREADS(T),
                .CNT_W(CNT_W), .REQ_W(REQ_W)) i_vl_cfg_unit (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_v), .cfg_int_used_i(iu),
    .cfg_fp_used_i(fu), .setvl_valid_i(sv_v), .setvl_req_i(req), .busy_o(busy),
    .max_len_o(max_len), .max_len_done_o(mdone), .vl_o(vl), .vl_done_o(vdone));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  int m_max = 0, m_vl = 0, m_pend = 0, m_timer = 0;
  bit m_busy = 0, m_mdone = 0, m_vdone = 0;

  function automatic int calc_max(int a, int b);
    int s = a + b;
    int q = (s < 2) ? R : R / (s - 1);
    int m = q * B;
    return (m > T) ? T : m;
  endfunction

  always @(posedge clk) if (rst_n) begin
    m_mdone = 0;
    m_vdone = 0;
    if (m_busy) begin
      m_timer--;
      if (m_timer == 0) begin m_max = m_pend; m_mdone = 1; m_busy = 0; end
    end else begin
      if (sv_v) begin m_vl = (int'(req) < m_max) ? int'(req) : m_max; m_vdone = 1; end
      if (cfg_v) begin m_pend = calc_max(int'(iu), int'(fu)); m_busy = 1; m_timer = DIV_W; end
    end
  end

  task automatic chk(string t, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(tag, "max_len", int'(max_len), m_max);
    chk(tag, "vl", int'(vl), m_vl);
    chk(tag, "busy", int'(busy), int'(m_busy));
    chk("R9", "max_len_done", int'(mdone), int'(m_mdone));
    chk("R9", "vl_done", int'(vdone), int'(m_vdone));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(bit c, int a, int b, bit s, int r);
    @(negedge clk);
    cfg_v = c; iu = CNT_W'(a); fu = CNT_W'(b); sv_v = s; req = REQ_W'(r);
    @(negedge clk);
    cfg_v = 0; sv_v = 0;
  endtask

  initial begin
    cyc(2);
    // R1 reset state
    chk("R1", "reset max_len", int'(max_len), 0);
    chk("R1", "reset vl", int'(vl), 0);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset dones", int'(mdone) + int'(vdone), 0);
    rst_n = 1'b1;
    cyc(2);
    tag = "R5"; drive(0, 0, 0, 1, 50); cyc(2);
    tag = "R2"; drive(1, 0, 0, 0, 0); cyc(DIV_W + 2);
    chk("R4", "clamped max", int'(max_len), T);
    tag = "R5"; drive(0, 0, 0, 1, 200); drive(0, 0, 0, 1, 17); cyc(1);
    chk("R5", "grant", int'(vl), 17);
    tag = "R3"; drive(1, 1, 2, 0, 0); cyc(DIV_W + 2);
    tag = "R8"; drive(1, 2, 2, 0, 0); cyc(DIV_W + 2);
    chk("R3", "sum4 max", int'(max_len), 80);
    chk("R8", "vl kept", int'(vl), 17);
    tag = "R5"; drive(0, 0, 0, 1, 100); cyc(1);
    tag = "R6"; drive(1, 3, 3, 0, 0);
    chk("R6", "busy after cfg", int'(busy), 1);
    tag = "R7"; drive(0, 0, 0, 1, 5); drive(1, 0, 1, 0, 0); cyc(DIV_W + 2);
    chk("R7", "ignored cfg", int'(max_len), 48);
    chk("R7", "ignored setvl", int'(vl), 80);
    tag = "R3"; drive(1, 40, 30, 0, 0); cyc(DIV_W + 2);
    chk("R3", "zero max", int'(max_len), 0);
    tag = "R5"; drive(0, 0, 0, 1, 9); cyc(1);
    tag = "R2"; drive(1, 1, 0, 0, 0); cyc(DIV_W + 2);
    tag = "R5"; drive(1, 4, 4, 1, 300); cyc(DIV_W + 2);
    chk("R5", "old max used", int'(vl), T);
    chk("R3", "sum8 max", int'(max_len), 32);
    tag = "R9"; drive(0, 0, 0, 1, 3); drive(0, 0, 0, 1, 7); cyc(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule